// File: doc/BRIEF.md
# Hardwired Instruction Cycle Controller

This block sequences a small accumulator machine through its instruction cycle. A fixed state machine walks through four cycles in order: fetch, an optional indirect pass, execute, and an interrupt cycle. Each cycle is made of timing steps of one clock each. In every step the controller issues register-transfer enables for the program counter, memory address register, memory buffer register, instruction register and accumulator, along with memory read and write strobes. Several transfers are packed into a single step where the register-usage rules allow it.

An instruction word is 16 bits wide. Bit 15 is the indirect flag, bits 14:12 hold the opcode and bits 11:0 hold the operand address. Three opcodes are decoded: an accumulate-from-memory, an increment-memory-and-skip-if-zero, and a branch that stores its return address. Every other opcode executes as a one-step no-op. The memory array sits outside the block. Its address is always the memory address register, and the read data must be valid within the read step itself.

Top module: `instr_cycle_ctrl`

## Requirements
- R1: While rst_n is low at a rising edge, the controller goes to fetch step t1 (cycle_o=0, step_o=0), with PC=0, accumulator=0 and interrupt enable=1.
- R2: Fetch takes three steps. It loads MAR from PC, then reads memory into MBR and increments PC in the same step, then copies MBR into IR.
- R3: When bit 15 of the fetched word is 1, a three-step indirect cycle (cycle_o=1) follows fetch. It replaces IR[11:0] with bits 11:0 of the word at the operand address, and execute (cycle_o=2) follows it.
- R4: Opcode 3'b001 adds the word at the operand address to the accumulator, modulo 2^16, in three execute steps.
- R5: Opcode 3'b010 takes four execute steps. It increments the word at the operand address and writes it back in the fourth step. In that same step PC is incremented once more if and only if the new value is zero.
- R6: Opcode 3'b011 takes three execute steps. It stores the zero-extended address of the following instruction at the operand address, and execution resumes at the operand address plus one.
- R7: Opcodes 3'b000 and 3'b100 through 3'b111 spend one execute step and change neither PC, the accumulator nor memory.
- R8: irq is sampled only in the last execute step, and only when interrupt enable is 1. If taken, a three-step interrupt cycle (cycle_o=3) writes PC to address 0x100, loads PC with 0x101 and clears interrupt enable, which never rises again until reset. A request at any other time is ignored.
- R9: mem_rd and mem_wr are never both high. mem_rd is high only in step t2 (step_o=1), so a memory read never shares a step with the IR load from MBR.
- R10: The cycles run in the order fetch, optional indirect, execute, optional interrupt, then fetch again. IR does not change during execute or interrupt.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| irq | input | 1 | Interrupt request level |
| mem_rdata | input | 16 | Word at mem_addr, valid combinationally |
| mem_addr | output | 12 | Memory address (MAR contents) |
| mem_wdata | output | 16 | Write data (MBR contents) |
| mem_rd | output | 1 | Read strobe; MBR captures mem_rdata at the end of this step |
| mem_wr | output | 1 | Write strobe; memory stores mem_wdata at the end of this step |
| pc_o | output | 12 | Program counter |
| ir_o | output | 16 | Instruction register |
| r1_o | output | 16 | Accumulator |
| ien_o | output | 1 | Interrupt enable flag |
| cycle_o | output | 2 | Current cycle: 0 fetch, 1 indirect, 2 execute, 3 interrupt |
| step_o | output | 2 | Current step within the cycle: 0 for t1 through 3 for t4 |

## Verification
The assertions assume that memory answers with no wait states. The word at mem_addr must be valid in the same step that mem_rd is raised, and a write must land at the rising edge that ends the mem_wr step. They also assume that irq is a level, held across the execute step in which it is sampled. The stimulus keeps to both. The bench memory reads combinationally from mem_addr and writes on the clock edge, and irq is set while reset is asserted and held constant for the whole run. An instruction-level reference model can therefore predict, for each instruction, exactly when the interrupt is taken and how many clocks the instruction lasts.

// File: rtl/icc_pkg.sv
// Shared types for the instruction cycle controller.
// Assumes a 3-bit opcode field; the cycle and step encodings are visible at the top ports.
package icc_pkg;

    typedef enum logic [1:0] {
        CY_FETCH = 2'd0,
        CY_IND   = 2'd1,
        CY_EXE   = 2'd2,
        CY_INT   = 2'd3
    } cyc_e;

    localparam logic [2:0] OP_ADD = 3'd1;
    localparam logic [2:0] OP_ISZ = 3'd2;
    localparam logic [2:0] OP_BSA = 3'd3;

    typedef enum logic [1:0] {MAR_HOLD, MAR_PC, MAR_IRA, MAR_SAVE} mar_sel_e;
    typedef enum logic [1:0] {MBR_HOLD, MBR_MEM, MBR_PC, MBR_INC} mbr_sel_e;
    typedef enum logic [2:0] {PC_HOLD, PC_INC, PC_IRA, PC_SVC, PC_SKIPZ} pc_sel_e;

    typedef struct packed {
        mar_sel_e mar_sel;
        mbr_sel_e mbr_sel;
        pc_sel_e  pc_sel;
        logic     ir_ld;
        logic     ira_ld;
        logic     r1_add;
        logic     mem_rd;
        logic     mem_wr;
        logic     ien_clr;
    } ctrl_t;

endpackage

// File: rtl/icc_sequencer.sv
// Cycle/step state machine: turns (cycle, step, opcode) into transfer enables.
// Assumes the indirect flag of the incoming word is presented from MBR during fetch t3.
module icc_sequencer
    import icc_pkg::*;
#(
    parameter int OPC_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             irq,
    input  logic             ien,
    input  logic             fetch_ind,
    input  logic [OPC_W-1:0] opc,
    output cyc_e             cyc,
    output logic [1:0]       step,
    output ctrl_t            ctrl
);

    cyc_e       cyc_q, cyc_d;
    logic [1:0] step_q, step_d;
    logic       exe_done;
    logic       op_add, op_isz, op_bsa, op_known;

    assign op_add   = (opc == OPC_W'(OP_ADD));
    assign op_isz   = (opc == OPC_W'(OP_ISZ));
    assign op_bsa   = (opc == OPC_W'(OP_BSA));
    assign op_known = op_add | op_isz | op_bsa;

    // Decode the current step into transfers and choose the next step.
    always_comb begin
        ctrl     = '0;
        cyc_d    = cyc_q;
        step_d   = step_q + 2'd1;
        exe_done = 1'b0;
        unique case (cyc_q)
            CY_FETCH: begin
                case (step_q)
                    2'd0: ctrl.mar_sel = MAR_PC;
                    2'd1: begin
                        ctrl.mbr_sel = MBR_MEM;
                        ctrl.mem_rd  = 1'b1;
                        ctrl.pc_sel  = PC_INC;
                    end
                    default: begin
                        ctrl.ir_ld = 1'b1;
                        cyc_d      = fetch_ind ? CY_IND : CY_EXE;
                        step_d     = 2'd0;
                    end
                endcase
            end
            CY_IND: begin
                case (step_q)
                    2'd0: ctrl.mar_sel = MAR_IRA;
                    2'd1: begin
                        ctrl.mbr_sel = MBR_MEM;
                        ctrl.mem_rd  = 1'b1;
                    end
                    default: begin
                        ctrl.ira_ld = 1'b1;
                        cyc_d       = CY_EXE;
                        step_d      = 2'd0;
                    end
                endcase
            end
            CY_EXE: begin
                case (step_q)
                    2'd0: begin
                        if (op_known) ctrl.mar_sel = MAR_IRA;
                        if (op_bsa)   ctrl.mbr_sel = MBR_PC;
                        if (!op_known) exe_done = 1'b1;
                    end
                    2'd1: begin
                        if (op_bsa) begin
                            ctrl.pc_sel = PC_IRA;
                            ctrl.mem_wr = 1'b1;
                        end else begin
                            ctrl.mbr_sel = MBR_MEM;
                            ctrl.mem_rd  = 1'b1;
                        end
                    end
                    2'd2: begin
                        if (op_add) begin
                            ctrl.r1_add = 1'b1;
                            exe_done    = 1'b1;
                        end else if (op_isz) begin
                            ctrl.mbr_sel = MBR_INC;
                        end else begin
                            ctrl.pc_sel = PC_INC;
                            exe_done    = 1'b1;
                        end
                    end
                    default: begin
                        ctrl.mem_wr = 1'b1;
                        ctrl.pc_sel = PC_SKIPZ;
                        exe_done    = 1'b1;
                    end
                endcase
            end
            default: begin
                case (step_q)
                    2'd0: begin
                        ctrl.mbr_sel = MBR_PC;
                        ctrl.ien_clr = 1'b1;
                    end
                    2'd1: begin
                        ctrl.mar_sel = MAR_SAVE;
                        ctrl.pc_sel  = PC_SVC;
                    end
                    default: begin
                        ctrl.mem_wr = 1'b1;
                        cyc_d       = CY_FETCH;
                        step_d      = 2'd0;
                    end
                endcase
            end
        endcase
        if (exe_done) begin
            cyc_d  = (irq && ien) ? CY_INT : CY_FETCH;
            step_d = 2'd0;
        end
    end

    // Hold the cycle and step; reset lands on fetch t1.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cyc_q  <= CY_FETCH;
            step_q <= 2'd0;
        end else begin
            cyc_q  <= cyc_d;
            step_q <= step_d;
        end
    end

    assign cyc  = cyc_q;
    assign step = step_q;

    AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(ctrl.mem_rd && ctrl.mem_wr)); // R9
    AST_RD_ONLY_T2: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl.mem_rd |-> (step_q == 2'd1)); // R9
    AST_IND_TO_EXE: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_q == CY_IND && step_q == 2'd2) |=> (cyc_q == CY_EXE && step_q == 2'd0)); // R3
    AST_INT_TO_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_q == CY_INT && step_q == 2'd2) |=> (cyc_q == CY_FETCH && step_q == 2'd0)); // R10
    AST_INT_ENTRY_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_q == CY_INT && step_q == 2'd0) |-> ($past(irq) && $past(ien))); // R8

endmodule

// File: rtl/icc_datapath.sv
// Register file of the machine: PC, MAR, MBR, IR, accumulator and interrupt enable.
// Assumes mem_rdata is valid combinationally for the current MAR during a read step.
module icc_datapath
    import icc_pkg::*;
#(
    parameter int               DATA_W    = 16,
    parameter int               ADDR_W    = 12,
    parameter logic [ADDR_W-1:0] SAVE_ADDR = 12'h100,
    parameter logic [ADDR_W-1:0] SVC_ADDR  = 12'h101
) (
    input  logic              clk,
    input  logic              rst_n,
    input  ctrl_t             ctrl,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] pc,
    output logic [ADDR_W-1:0] mar,
    output logic [DATA_W-1:0] mbr,
    output logic [DATA_W-1:0] ir,
    output logic [DATA_W-1:0] r1,
    output logic              ien
);

    logic [ADDR_W-1:0] pc_q, mar_q;
    logic [DATA_W-1:0] mbr_q, ir_q, r1_q;
    logic              ien_q;
    logic              mbr_zero;

    assign mbr_zero = (mbr_q == '0);

    // Program counter update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q <= '0;
        end else begin
            case (ctrl.pc_sel)
                PC_INC:   pc_q <= pc_q + 1'b1;
                PC_IRA:   pc_q <= ir_q[ADDR_W-1:0];
                PC_SVC:   pc_q <= SVC_ADDR;
                PC_SKIPZ: if (mbr_zero) pc_q <= pc_q + 1'b1;
                default:  pc_q <= pc_q;
            endcase
        end
    end

    // Memory address and buffer registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mar_q <= '0;
            mbr_q <= '0;
        end else begin
            case (ctrl.mar_sel)
                MAR_PC:   mar_q <= pc_q;
                MAR_IRA:  mar_q <= ir_q[ADDR_W-1:0];
                MAR_SAVE: mar_q <= SAVE_ADDR;
                default:  mar_q <= mar_q;
            endcase
            case (ctrl.mbr_sel)
                MBR_MEM: mbr_q <= mem_rdata;
                MBR_PC:  mbr_q <= DATA_W'(pc_q);
                MBR_INC: mbr_q <= mbr_q + 1'b1;
                default: mbr_q <= mbr_q;
            endcase
        end
    end

    // Instruction register, accumulator and interrupt enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ir_q  <= '0;
            r1_q  <= '0;
            ien_q <= 1'b1;
        end else begin
            if (ctrl.ir_ld)
                ir_q <= mbr_q;
            else if (ctrl.ira_ld)
                ir_q[ADDR_W-1:0] <= mbr_q[ADDR_W-1:0];
            if (ctrl.r1_add)
                r1_q <= r1_q + mbr_q;
            if (ctrl.ien_clr)
                ien_q <= 1'b0;
        end
    end

    assign pc  = pc_q;
    assign mar = mar_q;
    assign mbr = mbr_q;
    assign ir  = ir_q;
    assign r1  = r1_q;
    assign ien = ien_q;

    AST_IEN_ONE_WAY: assert property (@(posedge clk) disable iff (!rst_n)
        !$rose(ien_q)); // R8
    AST_NO_SKIP_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.pc_sel == PC_SKIPZ && !mbr_zero) |=> $stable(pc_q)); // R5

endmodule

// File: rtl/instr_cycle_ctrl.sv
// Top of the instruction cycle controller: sequencer plus register datapath.
// Assumes external memory with combinational read at mem_addr and write on the rising edge.
module instr_cycle_ctrl
    import icc_pkg::*;
#(
    parameter int               DATA_W    = 16,
    parameter int               ADDR_W    = 12,
    parameter logic [ADDR_W-1:0] SAVE_ADDR = 12'h100,
    parameter logic [ADDR_W-1:0] SVC_ADDR  = 12'h101
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              irq,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [ADDR_W-1:0] pc_o,
    output logic [DATA_W-1:0] ir_o,
    output logic [DATA_W-1:0] r1_o,
    output logic              ien_o,
    output logic [1:0]        cycle_o,
    output logic [1:0]        step_o
);

    localparam int OPC_W = DATA_W - ADDR_W - 1;

    cyc_e              cyc;
    logic [1:0]        step;
    ctrl_t             ctrl;
    logic [DATA_W-1:0] mbr, ir;
    logic              ien;

    icc_sequencer #(.OPC_W(OPC_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq       (irq),
        .ien       (ien),
        .fetch_ind (mbr[DATA_W-1]),
        .opc       (ir[DATA_W-2:ADDR_W]),
        .cyc       (cyc),
        .step      (step),
        .ctrl      (ctrl)
    );

    icc_datapath #(
        .DATA_W    (DATA_W),
        .ADDR_W    (ADDR_W),
        .SAVE_ADDR (SAVE_ADDR),
        .SVC_ADDR  (SVC_ADDR)
    ) u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctrl      (ctrl),
        .mem_rdata (mem_rdata),
        .pc        (pc_o),
        .mar       (mem_addr),
        .mbr       (mbr),
        .ir        (ir),
        .r1        (r1_o),
        .ien       (ien)
    );

    assign mem_wdata = mbr;
    assign mem_rd    = ctrl.mem_rd;
    assign mem_wr    = ctrl.mem_wr;
    assign ir_o      = ir;
    assign ien_o     = ien;
    assign cycle_o   = cyc;
    assign step_o    = step;

    AST_PC_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (cycle_o == 2'd0 && step_o == 2'd1) |=> (pc_o == $past(pc_o) + 1'b1)); // R2
    AST_IR_HELD_LATE: assert property (@(posedge clk) disable iff (!rst_n)
        (cycle_o == 2'd2 || cycle_o == 2'd3) |=> $stable(ir_o)); // R10

endmodule

// File: tb/instr_cycle_ctrl_bench.sv
// Scoreboard bench: an instruction-level model queues expected end-of-instruction
// state, a monitor pops one item per return to fetch t1 and compares.
module instr_cycle_ctrl_bench;

    localparam int          CLK_PERIOD = 10;
    localparam int          DW         = 16;
    localparam int          AW         = 12;
    localparam int          DEPTH      = 1 << AW;
    localparam logic [AW-1:0] SAVE     = 12'h100;
    localparam logic [AW-1:0] SVC      = 12'h101;

    typedef struct {
        logic [AW-1:0] pc;
        logic [DW-1:0] r1;
        logic          ien;
        int            clocks;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          irq = 1'b0;
    logic [DW-1:0] mem_rdata;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic          mem_rd, mem_wr;
    logic [AW-1:0] pc_o;
    logic [DW-1:0] ir_o, r1_o;
    logic          ien_o;
    logic [1:0]    cycle_o, step_o;

    logic [DW-1:0] mem [DEPTH];
    logic [DW-1:0] mdl [DEPTH];
    exp_t          exp_q[$];
    int            n_cmp = 0;
    int            n_bad = 0;
    int            strobe_viol = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    instr_cycle_ctrl u_instr_cycle_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq       (irq),
        .mem_rdata (mem_rdata),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rd    (mem_rd),
        .mem_wr    (mem_wr),
        .pc_o      (pc_o),
        .ir_o      (ir_o),
        .r1_o      (r1_o),
        .ien_o     (ien_o),
        .cycle_o   (cycle_o),
        .step_o    (step_o)
    );

    assign mem_rdata = mem[mem_addr];
    always @(posedge clk) if (mem_wr === 1'b1) mem[mem_addr] <= mem_wdata;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    task automatic clear_mem();
        for (int i = 0; i < DEPTH; i++) begin
            mem[i] = '0;
            mdl[i] = '0;
        end
    endtask

    task automatic put(input logic [AW-1:0] a, input logic [DW-1:0] v);
        mem[a] = v;
        mdl[a] = v;
    endtask

    // Driver: run the reference model and push one expected item per instruction.
    task automatic model_run(input int n, input bit irq_lvl);
        logic [AW-1:0] m_pc = '0;
        logic [DW-1:0] m_r1 = '0;
        logic          m_ien = 1'b1;
        logic [DW-1:0] w, v;
        logic [AW-1:0] a;
        int            c;
        exp_t          e;
        for (int i = 0; i < n; i++) begin
            w = mdl[m_pc];
            m_pc = m_pc + 1'b1;
            c = 3;
            a = w[AW-1:0];
            if (w[DW-1]) begin
                v = mdl[a];
                a = v[AW-1:0];
                c += 3;
            end
            case (w[DW-2:AW])
                3'd1: begin m_r1 = m_r1 + mdl[a]; c += 3; end
                3'd2: begin
                    v = mdl[a] + 1'b1;
                    mdl[a] = v;
                    if (v == '0) m_pc = m_pc + 1'b1;
                    c += 4;
                end
                3'd3: begin
                    mdl[a] = DW'(m_pc);
                    m_pc = a + 1'b1;
                    c += 3;
                end
                default: c += 1;
            endcase
            if (irq_lvl && m_ien) begin
                mdl[SAVE] = DW'(m_pc);
                m_pc = SVC;
                m_ien = 1'b0;
                c += 3;
            end
            e.pc = m_pc; e.r1 = m_r1; e.ien = m_ien; e.clocks = c;
            exp_q.push_back(e);
        end
    endtask

    // Monitor: compare architectural state and step count on each return to fetch t1.
    int   clk_cnt = 0;
    logic prev_ft1 = 1'b1;
    always @(negedge clk) begin
        if (!rst_n) begin
            clk_cnt  = 0;
            prev_ft1 = 1'b1;
        end else begin
            if (mem_rd === 1'b1 && mem_wr === 1'b1) strobe_viol++;
            if (mem_rd === 1'b1 && step_o !== 2'd1) strobe_viol++;
            if (cycle_o == 2'd0 && step_o == 2'd0 && !prev_ft1) begin
                if (exp_q.size() == 0) begin
                    check("R10 unexpected instruction boundary", 32'd1, 32'd0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check("R2/R6/R8 pc", 32'(pc_o), 32'(e.pc));
                    check("R4 accumulator", 32'(r1_o), 32'(e.r1));
                    check("R8 interrupt enable", 32'(ien_o), 32'(e.ien));
                    check("R10 clocks per instruction", 32'(clk_cnt), 32'(e.clocks));
                end
                clk_cnt = 1;
            end else begin
                clk_cnt++;
            end
            prev_ft1 = (cycle_o == 2'd0 && step_o == 2'd0);
        end
    end

    task automatic run_test(input bit irq_lvl);
        int diffs = 0;
        irq   = irq_lvl;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 cycle after reset", 32'(cycle_o), 32'd0);
        check("R1 step after reset", 32'(step_o), 32'd0);
        check("R1 pc after reset", 32'(pc_o), 32'd0);
        check("R1 accumulator after reset", 32'(r1_o), 32'd0);
        check("R1 ien after reset", 32'(ien_o), 32'd1);
        rst_n = 1'b1;
        while (exp_q.size() != 0) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        for (int i = 0; i < DEPTH; i++) if (mem[i] !== mdl[i]) diffs++;
        check("R5/R6/R7 memory image mismatches", 32'(diffs), 32'd0);
        check("R9 strobe violations", 32'(strobe_viol), 32'd0);
    endtask

    initial begin
        repeat (2) @(negedge clk);
        // Program one: every opcode, indirect forms, skip and no-skip.
        clear_mem();
        put(12'h000, 16'h1050);  // ADD 0x50
        put(12'h001, 16'h9051);  // ADD indirect via 0x51
        put(12'h002, 16'h2053);  // ISZ 0x53 (wraps to zero, skips)
        put(12'h003, 16'h1050);  // skipped
        put(12'h004, 16'h2054);  // ISZ 0x54 (no skip)
        put(12'h005, 16'h5123);  // unknown opcode
        put(12'h006, 16'h7FFF);  // unknown opcode
        put(12'h007, 16'h3060);  // BSA 0x60
        put(12'h061, 16'h1050);  // ADD 0x50
        put(12'h062, 16'hB055);  // BSA indirect via 0x55
        put(12'h071, 16'h0000);  // opcode zero
        put(12'h050, 16'h0007);
        put(12'h051, 16'h0052);
        put(12'h052, 16'hFFFC);
        put(12'h053, 16'hFFFF);
        put(12'h054, 16'h0005);
        put(12'h055, 16'h0070);
        model_run(10, 1'b0);
        run_test(1'b0);
        check("R5 wrapped word", 32'(mem[12'h053]), 32'h0000);
        check("R5 incremented word", 32'(mem[12'h054]), 32'h0006);
        check("R6 saved return address", 32'(mem[12'h060]), 32'h0008);
        check("R3/R6 indirect save", 32'(mem[12'h070]), 32'h0063);
        check("R7 opcode field untouched word", 32'(mem[12'h005]), 32'h5123);

        // Program two: interrupt held high, taken once only.
        clear_mem();
        put(12'h000, 16'h1050);
        put(12'h101, 16'h1050);
        put(12'h102, 16'h2056);
        put(12'h104, 16'h0000);
        put(12'h050, 16'h0002);
        put(12'h056, 16'hFFFF);
        model_run(4, 1'b1);
        run_test(1'b1);
        check("R8 saved pc at save address", 32'(mem[SAVE]), 32'h0001);
        check("R5 skip in service routine", 32'(mem[12'h056]), 32'h0000);

        summary();
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL R10 watchdog actual=hung expected=finished");
        summary();
        $finish;
    end

endmodule